// File: doc/BRIEF.md
# Sign-Driven Phase Step Controller

This block is the digital half of a loop that steers a sampling clock onto the zero crossings of an incoming sine wave. Each accepted cycle it receives one comparator decision: the sign of the latest tracking sample. It then moves a tap-select code one position along a ring of equally spaced delay-line taps. When the sample is positive, the sampling point is late, so the code steps down. When the sample is negative, the code steps up. The code never rests, so in lock it alternates between the two taps that bracket the true crossing.

The input is chopped upstream: every second tracking sample arrives inverted. The block undoes this with an internal polarity toggle, so that the loop only ever tracks rising crossings. The tap code runs modulo the tap count. Because of this, the block also keeps a small signed count of ring wraps. It combines that count with the code into one unwrapped phase value, which can tell apart delays spanning several reference periods.

Top module: `phase_step_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the tap code, wrap count, unwrapped phase and internal chop polarity all become 0. The first accepted decision after reset is used without inversion.
- R2: The effective sign is `dec_sign` XOR the chop polarity, where `dec_sign`=1 means a positive sample. The chop polarity flips on every accepted decision. An effective positive sign steps the code down, and an effective negative sign steps it up.
- R3: Every accepted decision (`dec_valid`=1) changes the tap code by exactly one position on the ring. The code is never left unchanged.
- R4: The tap code stays within 0..23. Stepping down from 0 gives 23, and stepping up from 23 gives 0.
- R5: The wrap count is a 3-bit two's complement value. It rises by one on a 23-to-0 step and falls by one on a 0-to-23 step. It is unchanged on all other steps.
- R6: The wrap count saturates at +3 and at -4. A wrap that would pass a limit leaves the count at that limit, while the code still wraps.
- R7: When `dec_valid` is low, the code, wrap count, unwrapped phase and chop polarity all hold. The value of `dec_sign` has no effect in that cycle.
- R8: `phase_unwrapped` is the 8-bit two's complement value of wrap_count*24 + tap_code, and it is always consistent with the other two outputs.
- R9: All outputs are registered. A decision presented before a clock edge is visible on the outputs just after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Qualifies the decision in this cycle |
| dec_sign | input | 1 | Raw comparator decision, 1 = positive sample |
| tap_code | output | 5 | Selected delay-line tap, 0..23 |
| wrap_count | output | 3 | Signed count of ring wraps, saturating |
| phase_unwrapped | output | 8 | Signed wrap_count*24 + tap_code |

## Verification
Two functions can act in the same cycle: the ring wrap of the code and the saturation of the wrap count. This happens when a step crosses the 23/0 boundary while the count already sits at +3 or -4. The bench provokes it by choosing raw signs against its own model of the chop polarity, so that the effective direction stays constant for more than seven full revolutions each way. In those cycles it judges that the code still wraps, that the count stays at its limit, and that the unwrapped value follows the formula. Random valid/sign traffic also lands in the chop inversion at the same time as a wrap, and every such cycle is compared against the bench model.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;
  typedef enum logic {STEP_UP = 1'b0, STEP_DOWN = 1'b1} step_dir_e;
endpackage

// File: rtl/phstep_chop.sv
module phstep_chop (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic raw_sign,
  output logic eff_positive
);
  logic chop_q;

  // Inverted polarity on every second accepted decision
  assign eff_positive = raw_sign ^ chop_q;

  always_ff @(posedge clk) begin
    if (rst)       chop_q <= 1'b0;
    else if (take) chop_q <= ~chop_q;
  end

  p_chop_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> chop_q != $past(chop_q));
  p_chop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(chop_q));
endmodule

// File: rtl/phstep_code.sv
module phstep_code
  import phase_step_pkg::*;
#(
  parameter int NUM_TAPS = 24,
  parameter int CODE_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  step_dir_e         step_dir,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_nxt,
  output logic              wrap_up,
  output logic              wrap_dn
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(NUM_TAPS - 1);
  localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

  always_comb begin
    code_nxt = code_q;
    wrap_up  = 1'b0;
    wrap_dn  = 1'b0;
    if (step_en) begin
      if (step_dir == STEP_DOWN) begin
        if (code_q == '0) begin
          code_nxt = LAST;
          wrap_dn  = 1'b1;
        end else begin
          code_nxt = code_q - ONE;
        end
      end else begin
        if (code_q == LAST) begin
          code_nxt = '0;
          wrap_up  = 1'b1;
        end else begin
          code_nxt = code_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_nxt;
  end

  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    step_en |=> ($past(step_dir) == STEP_DOWN)
      ? (code_q == (($past(code_q) == '0) ? LAST : $past(code_q) - ONE))
      : (code_q == (($past(code_q) == LAST) ? '0 : $past(code_q) + ONE)));
  p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
    code_q <= LAST);
  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(code_q));
endmodule

// File: rtl/phstep_wrap.sv
module phstep_wrap #(
  parameter int WRAP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_up,
  input  logic              wrap_dn,
  output logic [WRAP_W-1:0] wrap_q,
  output logic [WRAP_W-1:0] wrap_nxt
);
  localparam logic [WRAP_W-1:0] W_MAX = {1'b0, {(WRAP_W-1){1'b1}}};
  localparam logic [WRAP_W-1:0] W_MIN = {1'b1, {(WRAP_W-1){1'b0}}};
  localparam logic [WRAP_W-1:0] W_ONE = WRAP_W'(1);

  always_comb begin
    wrap_nxt = wrap_q;
    if (wrap_up && wrap_q != W_MAX)      wrap_nxt = wrap_q + W_ONE;
    else if (wrap_dn && wrap_q != W_MIN) wrap_nxt = wrap_q - W_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= '0;
    else     wrap_q <= wrap_nxt;
  end

  p_wrap_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!wrap_up && !wrap_dn) |=> $stable(wrap_q));
  p_wrap_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (wrap_up && wrap_q != W_MAX) |=> wrap_q == $past(wrap_q) + W_ONE);
  p_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (wrap_up && wrap_q == W_MAX) |=> wrap_q == W_MAX);
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (wrap_dn && wrap_q == W_MIN) |=> wrap_q == W_MIN);
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter int NUM_TAPS = 24,
  parameter int CODE_W   = 5,
  parameter int WRAP_W   = 3,
  localparam int UNW_W   = CODE_W + WRAP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic              dec_sign,
  output logic [CODE_W-1:0] tap_code,
  output logic [WRAP_W-1:0] wrap_count,
  output logic [UNW_W-1:0]  phase_unwrapped
);
  logic              eff_pos;
  logic [CODE_W-1:0] code_nxt;
  logic [WRAP_W-1:0] wrap_nxt;
  logic              w_up, w_dn;
  logic [UNW_W-1:0]  unw_nxt;
  step_dir_e         dir;

  phstep_chop u_chop (
    .clk(clk), .rst(rst), .take(dec_valid),
    .raw_sign(dec_sign), .eff_positive(eff_pos)
  );

  assign dir = eff_pos ? STEP_DOWN : STEP_UP;

  phstep_code #(.NUM_TAPS(NUM_TAPS), .CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .step_en(dec_valid), .step_dir(dir),
    .code_q(tap_code), .code_nxt(code_nxt), .wrap_up(w_up), .wrap_dn(w_dn)
  );

  phstep_wrap #(.WRAP_W(WRAP_W)) u_wrap (
    .clk(clk), .rst(rst), .wrap_up(w_up), .wrap_dn(w_dn),
    .wrap_q(wrap_count), .wrap_nxt(wrap_nxt)
  );

  // Two's complement: sign-extend count, scale by ring size, add code
  always_comb begin
    unw_nxt = {{(UNW_W-WRAP_W){wrap_nxt[WRAP_W-1]}}, wrap_nxt} * UNW_W'(NUM_TAPS)
            + {{(UNW_W-CODE_W){1'b0}}, code_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) phase_unwrapped <= '0;
    else     phase_unwrapped <= unw_nxt;
  end

  p_unwrap_r8: assert property (@(posedge clk) disable iff (rst)
    phase_unwrapped == UNW_W'({{(UNW_W-WRAP_W){wrap_count[WRAP_W-1]}}, wrap_count}
                               * UNW_W'(NUM_TAPS) + {{(UNW_W-CODE_W){1'b0}}, tap_code}));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> ($stable(tap_code) && $stable(wrap_count) && $stable(phase_unwrapped)));
endmodule

// File: tb/phase_step_ctrl_test.sv
`timescale 1ns/1ps
module phase_step_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic       dec_sign = 1'b0;
  logic [4:0] tap_code;
  logic [2:0] wrap_count;
  logic [7:0] phase_unwrapped;

  int n_checks = 0;
  int n_fail   = 0;
  int m_code = 0, m_wrap = 0, m_chop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_step_ctrl uut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_sign(dec_sign),
    .tap_code(tap_code), .wrap_count(wrap_count), .phase_unwrapped(phase_unwrapped)
  );

  function automatic int f_next_code(int c, bit down);
    if (down) return (c == 0) ? 23 : c - 1;
    return (c == 23) ? 0 : c + 1;
  endfunction

  function automatic int f_next_wrap(int w, int c, bit down);
    if (down && c == 0)  return (w == -4) ? -4 : w - 1;
    if (!down && c == 23) return (w == 3) ? 3 : w + 1;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " code"}, int'(tap_code), m_code);
    chk({req, " wrap"}, int'($signed(wrap_count)), m_wrap);
    chk({req, " unwrapped R8"}, int'($signed(phase_unwrapped)), m_wrap * 24 + m_code);
  endtask

  // Apply one cycle; outputs checked before and after the edge
  task automatic step(bit v, bit s, string req);
    @(negedge clk);
    dec_valid = v;
    dec_sign  = s;
    #1 chk("R9 pre-edge code", int'(tap_code), m_code);
    if (v) begin
      bit down;
      down   = s ^ m_chop[0];
      m_wrap = f_next_wrap(m_wrap, m_code, down);
      m_code = f_next_code(m_code, down);
      m_chop = m_chop ^ 1;
    end
    @(posedge clk);
    #1 chk_all(req);
  endtask

  // Choose raw sign so effective direction is as requested
  task automatic step_eff(bit down, string req);
    step(1'b1, down ^ m_chop[0], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_all("R1 reset");
    // R1/R2: first decision non-inverted, positive -> down, wraps 0->23 (R4, R5)
    step(1'b1, 1'b1, "R2 first-uninverted R4 R5");
    chk("R4 down-wrap code", int'(tap_code), 23);
    // second decision inverted: raw positive -> up, back to 0
    step(1'b1, 1'b1, "R2 chopped R4");
    chk("R4 up-wrap code", int'(tap_code), 0);
    // R7: invalid cycles with either sign hold everything
    step(1'b0, 1'b1, "R7 hold");
    step(1'b0, 1'b0, "R7 hold");
    // chop held: next decision still non-inverted
    step(1'b1, 1'b0, "R7 chop-held R2");
    chk("R2 up after hold", int'(tap_code), 1);
    // R6: drive down for 8 revolutions -> saturate at -4
    for (int i = 0; i < 8 * 24; i++) step_eff(1'b1, "R6 down-sat R3");
    chk("R6 low limit", int'($signed(wrap_count)), -4);
    // R6: drive up for 9 revolutions -> saturate at +3
    for (int i = 0; i < 9 * 24; i++) step_eff(1'b0, "R6 up-sat R3");
    chk("R6 high limit", int'($signed(wrap_count)), 3);
    // lock toggling between two taps (R3)
    for (int i = 0; i < 20; i++) step_eff(i[0], "R3 toggle");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      step(r != 0, 1'($urandom_range(0, 1)), "R2 R3 R5 random");
    end
    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    dec_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    dec_valid = 1'b0;
    m_code = 0; m_wrap = 0; m_chop = 0;
    chk_all("R1 re-reset");
    step(1'b1, 1'b0, "R1 chop cleared");
    chk("R1 first up", int'(tap_code), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule